// File: doc/BRIEF.md
# Windowed IR Carrier Demodulator

The block turns a modulated infrared input into a baseband mark/space level. A remote control sends marks as bursts of carrier cycles and spaces as silence. A pulse-width receiver further down the chain wants a clean level instead. The block times the distance between successive rising edges of the raw input in ticks of a divided receive clock. It accepts an edge only if that distance falls inside a tolerance window around the nominal carrier period of 16 ticks. Because the carrier is taken to have a 50% duty cycle, one edge direction carries all the timing information.

A two-bit select makes the window asymmetric. The lower tolerance and the upper tolerance can each be widened by one tick, independently. When demodulation is turned off, the raw input goes straight to the output through the output register, and the window logic has no effect.

Top module: `ir_carrier_demod`

## Requirements
- R1: While `rst` is sampled high, `level_out` is driven to 0 on the next clock edge.
- R2: With `demod_en` low, `level_out` equals the value of `din` sampled on the previous clock edge, whatever `tick` does.
- R3: The accepted distance between rising edges runs from 16−i to 16+j ticks inclusive. `win_sel[0]`=0 gives i=3, `win_sel[0]`=1 gives i=4. `win_sel[1]`=0 gives j=3, `win_sel[1]`=1 gives j=4.
- R4: With `demod_en` high, `level_out` rises after the second in-window interval in a row, that is on the third rising edge of a steady carrier. The first rising edge after reset never counts as in-window. `level_out` changes one clock after the tick that causes the change.
- R5: A carrier whose period is shorter than 16−i or longer than 16+j ticks never raises `level_out`.
- R6: Once `level_out` is high, it falls on the tick at which 16+j+1 ticks have passed since the last in-window edge with no new in-window edge.
- R7: A rising edge outside the window restarts qualification and does not delay the fall required by R6.
- R8: Only clock cycles with `tick` high advance the edge sampler and the interval timers. Any number of cycles with `tick` low leaves the demodulated level unchanged, even while `din` toggles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | One-cycle enable from the receive clock divider |
| din | input | 1 | Raw IR input, already synchronized |
| demod_en | input | 1 | 1 = demodulate, 0 = pass `din` through |
| win_sel | input | 2 | Tolerance select: bit 0 widens the lower tolerance, bit 1 widens the upper tolerance |
| level_out | output | 1 | Registered baseband level, 1 = mark |

## Verification
The assertions assume three things about the inputs. `win_sel` stays constant while demodulation runs. `tick` is a single-cycle pulse. `din` changes only between clock edges. The mark-duration bound in the checker is derived from the current `win_sel`, so it would be meaningless if the select moved mid-burst. The stimulus therefore changes `win_sel` only under reset. It raises `tick` for one cycle out of every three, and it updates `din` on falling clock edges together with the tick.

// File: rtl/ir_dm_pkg.sv
package ir_dm_pkg;

  typedef enum logic [1:0] {
    Q_IDLE = 2'd0,
    Q_ONE  = 2'd1,
    Q_LOCK = 2'd2
  } qual_state_e;

  function automatic int unsigned win_low(input int unsigned period,
                                          input int unsigned tol_base,
                                          input logic widen);
    return period - tol_base - (widen ? 1 : 0);
  endfunction

  function automatic int unsigned win_high(input int unsigned period,
                                           input int unsigned tol_base,
                                           input logic widen);
    return period + tol_base + (widen ? 1 : 0);
  endfunction

endpackage

// File: rtl/ir_dm_edge.sv
module ir_dm_edge #(
  parameter bit USE_RISE = 1'b1
) (
  input  logic clk,
  input  logic rst,
  input  logic tick,
  input  logic din,
  output logic edge_hit
);

  logic prev;

  always_ff @(posedge clk) begin
    if (rst)       prev <= 1'b0;
    else if (tick) prev <= din;
  end

  generate
    if (USE_RISE) begin : g_rise
      assign edge_hit = tick & din & ~prev;
    end else begin : g_fall
      assign edge_hit = tick & ~din & prev;
    end
  endgenerate

endmodule

// File: rtl/ir_dm_interval.sv
module ir_dm_interval #(
  parameter int unsigned PERIOD   = 16,
  parameter int unsigned TOL_BASE = 3,
  parameter int unsigned CW       = 5
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       tick,
  input  logic       edge_hit,
  input  logic [1:0] win_sel,
  output logic       valid_edge,
  output logic       bad_edge
);
  import ir_dm_pkg::*;

  localparam int unsigned GAP_MAX = PERIOD + TOL_BASE + 2;

  logic [CW-1:0] gap;
  logic [CW-1:0] lo_lim;
  logic [CW-1:0] hi_lim;
  logic          in_win;

  assign lo_lim = CW'(win_low(PERIOD, TOL_BASE, win_sel[0]));
  assign hi_lim = CW'(win_high(PERIOD, TOL_BASE, win_sel[1]));
  assign in_win = (gap >= lo_lim) && (gap <= hi_lim);

  assign valid_edge = edge_hit & in_win;
  assign bad_edge   = edge_hit & ~in_win;

  always_ff @(posedge clk) begin
    if (rst) begin
      gap <= CW'(GAP_MAX);
    end else if (tick) begin
      if (edge_hit)                 gap <= CW'(1);
      else if (gap != CW'(GAP_MAX)) gap <= gap + CW'(1);
    end
  end

endmodule

// File: rtl/ir_dm_qual.sv
module ir_dm_qual #(
  parameter int unsigned PERIOD   = 16,
  parameter int unsigned TOL_BASE = 3,
  parameter int unsigned CW       = 5
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          tick,
  input  logic          valid_edge,
  input  logic          bad_edge,
  input  logic [1:0]    win_sel,
  output logic          mark,
  output logic [CW-1:0] since_valid
);
  import ir_dm_pkg::*;

  localparam int unsigned SV_MAX = PERIOD + TOL_BASE + 2;

  qual_state_e   state;
  logic [CW-1:0] expire_at;
  logic          expired;

  assign expire_at = CW'(win_high(PERIOD, TOL_BASE, win_sel[1]) + 1);
  assign expired   = tick & ~valid_edge & (since_valid >= expire_at);

  always_ff @(posedge clk) begin
    if (rst) begin
      since_valid <= CW'(SV_MAX);
    end else if (tick) begin
      if (valid_edge)                       since_valid <= CW'(1);
      else if (since_valid != CW'(SV_MAX))  since_valid <= since_valid + CW'(1);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= Q_IDLE;
      mark  <= 1'b0;
    end else if (tick) begin
      if (valid_edge) begin
        if (state == Q_IDLE) begin
          state <= Q_ONE;
        end else begin
          state <= Q_LOCK;
          mark  <= 1'b1;
        end
      end else begin
        if (bad_edge || expired) state <= Q_IDLE;
        if (expired)             mark  <= 1'b0;
      end
    end
  end

endmodule

// File: rtl/ir_carrier_demod.sv
module ir_carrier_demod #(
  parameter int unsigned PERIOD   = 16,
  parameter int unsigned TOL_BASE = 3,
  parameter bit          USE_RISE = 1'b1
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       tick,
  input  logic       din,
  input  logic       demod_en,
  input  logic [1:0] win_sel,
  output logic       level_out
);

  localparam int unsigned CW = $clog2(PERIOD + TOL_BASE + 3);

  logic          edge_hit;
  logic          valid_edge;
  logic          bad_edge;
  logic          mark;
  logic [CW-1:0] since_valid;

  ir_dm_edge #(.USE_RISE(USE_RISE)) u_edge (
    .clk      (clk),
    .rst      (rst),
    .tick     (tick),
    .din      (din),
    .edge_hit (edge_hit)
  );

  ir_dm_interval #(.PERIOD(PERIOD), .TOL_BASE(TOL_BASE), .CW(CW)) u_interval (
    .clk        (clk),
    .rst        (rst),
    .tick       (tick),
    .edge_hit   (edge_hit),
    .win_sel    (win_sel),
    .valid_edge (valid_edge),
    .bad_edge   (bad_edge)
  );

  ir_dm_qual #(.PERIOD(PERIOD), .TOL_BASE(TOL_BASE), .CW(CW)) u_qual (
    .clk         (clk),
    .rst         (rst),
    .tick        (tick),
    .valid_edge  (valid_edge),
    .bad_edge    (bad_edge),
    .win_sel     (win_sel),
    .mark        (mark),
    .since_valid (since_valid)
  );

  always_ff @(posedge clk) begin
    if (rst) level_out <= 1'b0;
    else     level_out <= demod_en ? mark : din;
  end

endmodule

// File: rtl/ir_carrier_demod_chk.sv
module ir_carrier_demod_chk #(
  parameter int unsigned PERIOD   = 16,
  parameter int unsigned TOL_BASE = 3,
  parameter int unsigned CW       = 5
) (
  input logic          clk,
  input logic          rst,
  input logic          tick,
  input logic          din,
  input logic          demod_en,
  input logic [1:0]    win_sel,
  input logic          level_out,
  input logic          mark,
  input logic          valid_edge,
  input logic [CW-1:0] since_valid
);

  AST_RESET_CLEARS: assert property (@(posedge clk) rst |=> !level_out); // R1

  AST_PASS_RAW: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(demod_en)) |-> (level_out == $past(din))); // R2

  AST_OUT_TRACKS_MARK: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(demod_en)) |-> (level_out == $past(mark))); // R4

  AST_MARK_NEEDS_VALID: assert property (@(posedge clk) disable iff (rst)
    $rose(mark) |-> $past(valid_edge)); // R4

  AST_MARK_BOUNDED: assert property (@(posedge clk) disable iff (rst)
    mark |-> (int'(since_valid) <= int'(PERIOD + TOL_BASE + 1) + int'(win_sel[1]))); // R6

  AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (rst)
    !tick |=> $stable(mark)); // R8

endmodule

bind ir_carrier_demod ir_carrier_demod_chk #(
  .PERIOD(PERIOD), .TOL_BASE(TOL_BASE), .CW(CW)
) u_chk (
  .clk         (clk),
  .rst         (rst),
  .tick        (tick),
  .din         (din),
  .demod_en    (demod_en),
  .win_sel     (win_sel),
  .level_out   (level_out),
  .mark        (mark),
  .valid_edge  (valid_edge),
  .since_valid (since_valid)
);

// File: tb/ir_carrier_demod_tb.sv
`timescale 1ns/1ps
module ir_carrier_demod_tb;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       tick = 1'b0;
  logic       din = 1'b0;
  logic       demod_en = 1'b1;
  logic [1:0] win_sel = 2'd0;
  logic       level_out;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  ir_carrier_demod u_dut (
    .clk(clk), .rst(rst), .tick(tick), .din(din),
    .demod_en(demod_en), .win_sel(win_sel), .level_out(level_out)
  );

  // {win_sel, carrier period in ticks, expected level after third rising edge}
  localparam int NVEC = 13;
  localparam int VEC [NVEC][3] = '{
    '{0, 16, 1}, '{0, 13, 1}, '{0, 12, 0}, '{1, 12, 1}, '{0, 19, 1},
    '{0, 20, 0}, '{2, 20, 1}, '{3, 12, 1}, '{3, 20, 1}, '{3, 11, 0},
    '{3, 21, 0}, '{1, 20, 0}, '{2, 12, 0}
  };

  task automatic chk(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: level_out=%b expected=%b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic do_reset(input logic [1:0] sel);
    @(negedge clk);
    rst = 1'b1; tick = 1'b0; din = 1'b0; win_sel = sel; demod_en = 1'b1;
    repeat (2) @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic one_tick(input logic v);
    @(negedge clk); din = v; tick = 1'b1;
    @(negedge clk); tick = 1'b0;
    @(negedge clk);
  endtask

  task automatic run_ticks(input logic v, input int n);
    for (int k = 0; k < n; k++) one_tick(v);
  endtask

  task automatic carrier(input int p, input int cycles);
    for (int c = 0; c < cycles; c++) begin
      run_ticks(1'b1, p / 2);
      run_ticks(1'b0, p - p / 2);
    end
  endtask

  initial begin
    // R1: reset holds output low even with raw input high in pass-through
    @(negedge clk); rst = 1'b1; demod_en = 1'b0; din = 1'b1;
    @(negedge clk);
    chk("R1", level_out, 1'b0);
    rst = 1'b0;
    @(negedge clk);
    chk("R2", level_out, 1'b1);

    // R2: pass-through follows din one clock later, no tick needed
    din = 1'b0; @(negedge clk);
    chk("R2", level_out, 1'b0);
    din = 1'b1; @(negedge clk);
    chk("R2", level_out, 1'b1);

    // R3 / R5: window table
    for (int v = 0; v < NVEC; v++) begin
      do_reset(VEC[v][0][1:0]);
      carrier(VEC[v][1], 2);
      run_ticks(1'b1, VEC[v][1] / 2);
      chk(VEC[v][2] != 0 ? "R3" : "R5", level_out, VEC[v][2] != 0);
    end

    // R4: two edges are not enough, the third raises the mark
    do_reset(2'd0);
    carrier(16, 1);
    run_ticks(1'b1, 1);
    chk("R4", level_out, 1'b0);
    run_ticks(1'b1, 7); run_ticks(1'b0, 8);
    run_ticks(1'b1, 1);
    chk("R4", level_out, 1'b1);

    // R6: timeout with upper tolerance 3 -> falls at 20 ticks after last valid edge
    do_reset(2'd0);
    carrier(16, 3);
    run_ticks(1'b0, 4);
    chk("R6", level_out, 1'b1);
    run_ticks(1'b0, 1);
    chk("R6", level_out, 1'b0);

    // R6: upper tolerance 4 -> falls at 21 ticks
    do_reset(2'd2);
    carrier(16, 3);
    run_ticks(1'b0, 5);
    chk("R6", level_out, 1'b1);
    run_ticks(1'b0, 1);
    chk("R6", level_out, 1'b0);

    // R7: an out-of-window edge at 10 ticks does not push back the timeout
    do_reset(2'd0);
    carrier(16, 2);
    run_ticks(1'b1, 5);
    run_ticks(1'b0, 5);
    run_ticks(1'b1, 10);
    chk("R7", level_out, 1'b1);
    run_ticks(1'b1, 1);
    chk("R7", level_out, 1'b0);

    // R8: cycles without tick leave the mark alone while din toggles
    do_reset(2'd0);
    carrier(16, 2);
    run_ticks(1'b1, 1);
    chk("R8", level_out, 1'b1);
    for (int k = 0; k < 100; k++) begin
      @(negedge clk); din = ~din;
    end
    chk("R8", level_out, 1'b1);

    // R2: switching off demodulation exposes the raw input
    @(negedge clk); demod_en = 1'b0; din = 1'b0;
    @(negedge clk);
    chk("R2", level_out, 1'b0);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: level_out=%b expected=finished run", level_out);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

endmodule